// File: doc/BRIEF.md
# Debug-Halt Status Flag Clear Guard

This block holds a small bank of sticky status flags and decides when software may clear them. Each flag is raised by a one-cycle set event from the peripheral that owns it. Software clears a flag with a two-step sequence. The first step is a read of the status register while the flag is set, which arms the flag. The second step is a read or write of the associated data register, which clears every armed flag.

A guard sits in front of the clear logic. While a debug breakpoint holds the system halted (`halt_act` high), a debugger may inspect registers freely. When `halt_clr_ok` is 0, no access during the halt can clear, arm or disarm anything. When `halt_clr_ok` is 1, the normal clearing rules apply during the halt. Any arming done before the halt survives it, so the second step still clears the flag once the halt is over.

The data register is a plain storage register of `DW` bits. Reads return either the flags or that register on a combinational read bus.

Top module: `fb_status_bank`

## Requirements
- R1: A set event on `flag_set[i]` makes `flags[i]` 1 in the next cycle, and the flag stays 1 until it is cleared by the two-step sequence.
- R2: With clearing allowed, a status read (`stat_rd`) while `flags[i]` is 1 arms flag i. A later data-register read (`data_rd`) or write (`data_wr`), also with clearing allowed, then makes `flags[i]` 0 in the following cycle.
- R3: A data-register access to a flag that is not armed leaves the flag unchanged.
- R4: While `halt_act`=1 and `halt_clr_ok`=0, no access changes any flag, and data-register accesses do not remove an existing arming.
- R5: A status read made while `halt_act`=1 and `halt_clr_ok`=0 does not arm. A data access after the halt ends therefore leaves the flag set.
- R6: While `halt_act`=1 and `halt_clr_ok`=1, the two-step sequence clears flags exactly as it does outside a halt.
- R7: A flag cleared during a halt stays 0 after `halt_act` falls.
- R8: A flag armed before a halt is cleared by the first data-register access made after `halt_act` falls.
- R9: When a set event and a clearing data access hit the same flag in the same cycle, the flag stays 1 and its arming is cancelled. A further data access without a new status read leaves it at 1.
- R10: Any data-register access made with clearing allowed disarms all flags. Only flags that were set at the time of the status read are armed, so a flag raised after that read survives the following data access.
- R11: With `stat_rd`=1, `rdata` shows the flags in bits NF-1:0 (flag i in bit i) and zeros above. With only `data_rd`=1, `rdata` shows the data register. With neither, `rdata` is 0. A `data_wr` loads `wdata` into the data register.
- R12: After reset, all flags, all arming state and the data register are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flag_set | input | NF | One-cycle set events, one per flag |
| halt_act | input | 1 | High while a debug breakpoint holds the system halted |
| halt_clr_ok | input | 1 | 1 lets clearing work during a halt |
| stat_rd | input | 1 | Status register read strobe (first step) |
| data_rd | input | 1 | Data register read strobe (second step) |
| data_wr | input | 1 | Data register write strobe (second step) |
| wdata | input | DW | Write data for the data register |
| flags | output | NF | Current flag values |
| rdata | output | DW | Read data bus |

## Verification
On every cycle, the assertions check the following per flag:
- a set event always lands;
- a protected halt keeps a set flag set and an unarmed flag unarmed;
- arming only exists on a set flag;
- a flag only falls after an armed, qualified second step;
- any qualified second step leaves the flag disarmed.

Some behaviours depend on order across several cycles and on halt entry and exit. These are shown only by the bench's scenarios, which compare every cycle against a behavioural model. They cover arming before a halt and clearing after it, a status read inside a protected halt that does not arm, a clear that persists after the halt, collisions between a set event and a clear, and the read-bus contents.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // Qualified bus controls shared by every flag cell
  typedef struct packed {
    logic allow;   // clearing permitted this cycle
    logic arm_rd;  // status read that may arm
    logic step2;   // data access that may clear / disarm
  } fb_ctl_t;
endpackage

// File: rtl/fb_guard.sv
module fb_guard
  import fb_pkg::*;
(
  input  logic    halt_act,
  input  logic    halt_clr_ok,
  input  logic    stat_rd,
  input  logic    data_rd,
  input  logic    data_wr,
  output fb_ctl_t ctl
);
  logic allow;

  always_comb begin
    allow      = !halt_act || halt_clr_ok;
    ctl.allow  = allow;
    ctl.arm_rd = stat_rd && allow;
    ctl.step2  = (data_rd || data_wr) && allow;
  end
endmodule

// File: rtl/fb_flag_cell.sv
module fb_flag_cell
  import fb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    set_i,
  input  fb_ctl_t ctl,
  output logic    flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic flag_en, arm_en;

  // next-state
  always_comb begin
    flag_en = set_i || (ctl.step2 && arm_q);
    flag_d  = set_i;  // set wins over a concurrent clear
    arm_en  = ctl.step2 || (ctl.arm_rd && flag_q);
    arm_d   = !ctl.step2;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (arm_en)  arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  assert_arm_on_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> flag_q);
  assert_clear_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q && ctl.step2 && !set_i));
  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.allow && flag_q) |=> flag_q);
  assert_halt_noarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.allow && !arm_q) |=> !arm_q);
  assert_step2_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step2 |=> !arm_q);
endmodule

// File: rtl/fb_readback.sv
module fb_readback #(
  parameter int NF = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic [NF-1:0] flags,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] dreg_q, dreg_d;

  always_comb begin
    dreg_d = wdata;
    if (stat_rd)      rdata = DW'(flags);
    else if (data_rd) rdata = dreg_q;
    else              rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dreg_q <= '0;
    else if (data_wr) dreg_q <= dreg_d;
  end

  assert_dreg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> dreg_q == $past(wdata));
endmodule

// File: rtl/fb_status_bank.sv
module fb_status_bank
  import fb_pkg::*;
#(
  parameter int NF = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flag_set,
  input  logic          halt_act,
  input  logic          halt_clr_ok,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic [NF-1:0] flags,
  output logic [DW-1:0] rdata
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  fb_ctl_t           ctl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  fb_guard u_guard (
    .halt_act    (halt_act),
    .halt_clr_ok (halt_clr_ok),
    .stat_rd     (stat_rd),
    .data_rd     (data_rd),
    .data_wr     (data_wr),
    .ctl         (ctl)
  );

  for (genvar i = 0; i < NF; i++) begin : g_cell
    fb_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_i  (flag_set[i]),
      .ctl    (ctl),
      .flag_o (flags[i])
    );
  end

  fb_readback #(.NF(NF), .DW(DW)) u_rb (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .data_wr (data_wr),
    .wdata   (wdata),
    .flags   (flags),
    .rdata   (rdata)
  );
endmodule

// File: tb/sim_fb_status_bank.sv
module sim_fb_status_bank;
  localparam int NF = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF-1:0] flag_set;
  logic          halt_act, halt_clr_ok, stat_rd, data_rd, data_wr;
  logic [DW-1:0] wdata;
  logic [NF-1:0] flags;
  logic [DW-1:0] rdata;

  int errors = 0;
  int checks = 0;
  bit mflag [NF];
  bit marm  [NF];
  logic [DW-1:0] mdreg;

  always #2 clk = ~clk;  // 250 MHz

  fb_status_bank #(.NF(NF), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .halt_act(halt_act),
    .halt_clr_ok(halt_clr_ok), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .wdata(wdata), .flags(flags), .rdata(rdata)
  );

  task automatic chk(input string what, input logic [31:0] act,
                     input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NF-1:0] mflags();
    logic [NF-1:0] v;
    for (int i = 0; i < NF; i++) v[i] = mflag[i];
    return v;
  endfunction

  // one clock: drive, check read bus, advance model, check flags
  task automatic cyc(input logic [NF-1:0] s, input logic b, input logic e,
                     input logic sr, input logic dr, input logic dw,
                     input logic [DW-1:0] wd, input string tag);
    logic [DW-1:0] exp_rd;
    bit allow, s2;
    bit nf [NF];
    bit na [NF];
    flag_set = s; halt_act = b; halt_clr_ok = e;
    stat_rd = sr; data_rd = dr; data_wr = dw; wdata = wd;
    #1;
    if (sr)      exp_rd = DW'(mflags());
    else if (dr) exp_rd = mdreg;
    else         exp_rd = '0;
    chk("rdata", rdata, exp_rd, tag);
    @(posedge clk);
    allow = !b || e;
    s2 = (dr || dw) && allow;
    for (int i = 0; i < NF; i++) begin
      if (s[i])               nf[i] = 1'b1;
      else if (s2 && marm[i]) nf[i] = 1'b0;
      else                    nf[i] = mflag[i];
      if (s2)                            na[i] = 1'b0;
      else if (sr && allow && mflag[i])  na[i] = 1'b1;
      else                               na[i] = marm[i];
    end
    for (int i = 0; i < NF; i++) begin
      mflag[i] = nf[i];
      marm[i]  = na[i];
    end
    if (dw) mdreg = wd;
    #1;
    chk("flags", flags, mflags(), tag);
  endtask

  task automatic idle(input string tag);
    cyc('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    flag_set = '0; halt_act = 0; halt_clr_ok = 0;
    stat_rd = 0; data_rd = 0; data_wr = 0; wdata = '0;
    for (int i = 0; i < NF; i++) begin mflag[i] = 0; marm[i] = 0; end
    mdreg = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("flags", flags, '0, "R12");
    cyc('0, 0, 0, 1, 0, 0, '0, "R12");
    cyc('0, 0, 0, 0, 1, 0, '0, "R12");

    // R1 set and hold
    cyc(4'b0101, 0, 0, 0, 0, 0, '0, "R1");
    idle("R1");
    chk("flags", flags, 4'b0101, "R1");
    // R3 data access without arming
    cyc('0, 0, 0, 0, 1, 0, '0, "R3");
    chk("flags", flags, 4'b0101, "R3");
    // R2 and R11 two-step clear with write
    cyc('0, 0, 0, 1, 0, 0, '0, "R11");
    cyc('0, 0, 0, 0, 0, 1, 8'hA5, "R2");
    chk("flags", flags, 4'b0000, "R2");
    cyc('0, 0, 0, 0, 1, 0, '0, "R11");

    // R4 protected halt: no arm, no clear
    cyc(4'b0010, 1, 0, 0, 0, 0, '0, "R4");
    cyc('0, 1, 0, 1, 0, 0, '0, "R4");
    cyc('0, 1, 0, 0, 1, 0, '0, "R4");
    cyc('0, 1, 0, 0, 0, 1, 8'h3C, "R4");
    chk("flags", flags, 4'b0010, "R4");
    // R8 arm before halt, access inside halt, clear after
    cyc(4'b1000, 0, 0, 0, 0, 0, '0, "R8");
    cyc('0, 0, 0, 1, 0, 0, '0, "R8");
    cyc('0, 1, 0, 0, 1, 0, '0, "R4");
    chk("flags", flags, 4'b1010, "R4");
    cyc('0, 1, 0, 0, 0, 1, 8'h11, "R4");
    cyc('0, 0, 0, 0, 1, 0, '0, "R8");
    chk("flags", flags, 4'b0000, "R8");

    // R5 status read in protected halt does not arm
    cyc(4'b0001, 0, 0, 0, 0, 0, '0, "R5");
    cyc('0, 1, 0, 1, 0, 0, '0, "R5");
    idle("R5");
    cyc('0, 0, 0, 0, 1, 0, '0, "R5");
    chk("flags", flags, 4'b0001, "R5");
    cyc('0, 0, 0, 1, 0, 0, '0, "R5");
    cyc('0, 0, 0, 0, 1, 0, '0, "R5");

    // R6 clearing enabled during halt, R7 stays cleared
    cyc(4'b0100, 1, 1, 0, 0, 0, '0, "R6");
    cyc('0, 1, 1, 1, 0, 0, '0, "R6");
    cyc('0, 1, 1, 0, 0, 1, 8'h5A, "R6");
    chk("flags", flags, 4'b0000, "R6");
    idle("R7");
    idle("R7");
    chk("flags", flags, 4'b0000, "R7");

    // R9 set collides with clear
    cyc(4'b0001, 0, 0, 0, 0, 0, '0, "R9");
    cyc('0, 0, 0, 1, 0, 0, '0, "R9");
    cyc(4'b0001, 0, 0, 0, 1, 0, '0, "R9");
    chk("flags", flags, 4'b0001, "R9");
    cyc('0, 0, 0, 0, 1, 0, '0, "R9");
    chk("flags", flags, 4'b0001, "R9");
    cyc('0, 0, 0, 1, 0, 0, '0, "R9");
    cyc('0, 0, 0, 0, 1, 0, '0, "R9");

    // R10 flag raised after the status read survives
    cyc(4'b0010, 0, 0, 0, 0, 0, '0, "R10");
    cyc('0, 0, 0, 1, 0, 0, '0, "R10");
    cyc(4'b0100, 0, 0, 0, 0, 0, '0, "R10");
    cyc('0, 0, 0, 0, 1, 0, '0, "R10");
    chk("flags", flags, 4'b0100, "R10");

    // mixed traffic against the model
    for (int k = 0; k < 2000; k++) begin
      cyc(NF'($urandom) & NF'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
          DW'($urandom), "mixed");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule